// File: doc/BRIEF.md
# TDM Transmit Channel Selector

This block sits next to the transmit shifter of a time-division-multiplexed serial port. For every word slot of a frame it decides whether the slot consumes a transmit word and whether the data pin is driven or left floating. It counts the word slots itself. A frame-sync pulse sets the count to slot 0, and each word-boundary strobe after that moves it on by one slot. The count wraps after a programmable frame length of 1 to 128 words.

Software supplies a 2-bit selection mode, a range bit, and two 128-bit bitmaps: the transmit bitmap and the receive bitmap. Enabling and masking are separate decisions. An enabled slot takes a word from the transmit queue. An unmasked slot drives the pin. The tri-state output enable is high only when a slot is both enabled and unmasked.

In 32-channel range the frame is split into 16-slot blocks. The blocks alternate between partition A and partition B, starting with A at frame sync. Each slot's bit is taken from the active partition's 16-bit half of the bitmap.

Top module: `tdm_tx_chan_sel`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `chan_idx` is 0, `part_b` is 0, and `slot_enable`, `slot_unmask` and `pin_oe` are all 0.
- R2: A clock edge with `frame_sync` high starts a frame. After that edge `chan_idx` is 0, `part_b` is 0, and the three flags reflect slot 0. A frame sync in the middle of a frame re-aligns the count in the same way.
- R3: After a frame has started, an edge with `slot_strobe` high and `frame_sync` low moves `chan_idx` up by one. When `chan_idx` equals `frame_len_m1`, the same edge sets it to 0 instead. Between boundaries `chan_idx` and the flags do not change.
- R4: Mode 2'b00 sets enable and unmask for every slot, whatever the bitmaps hold.
- R5: Mode 2'b01 sets enable and unmask only where the slot's transmit bit is 1. Both are 0 otherwise.
- R6: Mode 2'b10 sets enable for every slot and sets unmask only where the transmit bit is 1. A masked slot therefore consumes a word while `pin_oe` stays 0.
- R7: Mode 2'b11 sets enable only where the slot's receive bit is 1, and sets unmask only where both the receive bit and the transmit bit are 1.
- R8: With `wide_range` = 0, `part_b` equals bit 4 of `chan_idx`. The slot's bit is read from map bit `16*part_b + chan_idx mod 16`, and map bits 32 to 127 have no effect.
- R9: With `wide_range` = 1, the slot's bit is read from map bit `chan_idx`.
- R10: `pin_oe` is 1 exactly when `slot_enable` and `slot_unmask` are both 1, so a disabled slot always leaves the pin floating.
- R11: Mode, range and bitmaps are sampled only at a slot boundary. A change made in the middle of a slot shows up at the next boundary.
- R12: Before the first frame sync after reset, strobes are ignored: `chan_idx` stays 0 and all flags stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | Frame start pulse, marks the boundary of slot 0 |
| slot_strobe | input | 1 | Word boundary pulse, one cycle per slot |
| sel_mode | input | 2 | Selection mode (00 all, 01 enable-select, 10 mask-select, 11 symmetric) |
| wide_range | input | 1 | 1: 128 individually selectable channels; 0: 32 with partitions |
| frame_len_m1 | input | 7 | Frame length in words minus one |
| tx_map | input | 128 | Transmit enable bitmap |
| rx_map | input | 128 | Receive enable bitmap |
| chan_idx | output | 7 | Current slot number |
| part_b | output | 1 | Active partition (0 = A, 1 = B) |
| slot_enable | output | 1 | Slot consumes a transmit word |
| slot_unmask | output | 1 | Slot data is driven on the pin |
| pin_oe | output | 1 | Output enable for the tri-state data driver |

## Verification
The bench goes after several corner cases, and each one has a clear failure signature.

- **Frame wrap.** A counter that wraps one slot late or early shows up as a non-zero channel after the last slot of a 40-word frame.
- **Partition after block 1.** In 32-channel range with a 64-word frame, slot 40 must read partition A's bit 8 and not map bit 40. A design that indexes the full map there drives the pin in the wrong slots.
- **Masked but enabled slots.** Modes 10 and 11 are driven with patterns that leave slots enabled but masked. Merging the two flags would drop words or drive the pin in those slots.
- **Mid-slot and pre-sync changes.** The bitmap is changed in the middle of a slot, and strobes are sent before any frame sync. Combinational flags, or a counter that runs without a frame sync, show up as early changes on the pin.

// File: rtl/tdm_sel_pkg.sv
// Package: shared mode encoding and per-slot flag type for the
// TDM transmit channel selector. No assumptions beyond 2-bit modes.
package tdm_sel_pkg;

    typedef enum logic [1:0] {
        SEL_ALL     = 2'b00,   // every slot enabled and unmasked
        SEL_TX_EN   = 2'b01,   // transmit bit enables and unmasks
        SEL_TX_MASK = 2'b10,   // all enabled, transmit bit unmasks
        SEL_SYM     = 2'b11    // receive bit enables, both bits unmask
    } sel_mode_e;

    typedef struct packed {
        logic en;
        logic unmask;
    } slot_flags_t;

endpackage

// File: rtl/tdm_slot_counter.sv
// Slot counter: tracks the current slot number and the active 16-slot
// partition. Assumes frame_sync and slot_strobe are single-cycle pulses
// and that frame_len_m1 is held steady during a frame.
module tdm_slot_counter #(
    parameter int MAX_CH  = 128,
    parameter int PART_CH = 16,
    localparam int CH_W   = $clog2(MAX_CH),
    localparam int PB     = $clog2(PART_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_sync,
    input  logic            slot_strobe,
    input  logic [CH_W-1:0] frame_len_m1,
    output logic            run_q,
    output logic [CH_W-1:0] chan_q,
    output logic            part_q,
    output logic [CH_W-1:0] nxt_chan,
    output logic            nxt_part,
    output logic            boundary
);

    logic [CH_W-1:0] inc;

    assign inc = chan_q + 1'b1;

    // Next slot number and partition at a boundary
    always_comb begin
        nxt_chan = chan_q;
        nxt_part = part_q;
        boundary = 1'b0;
        if (frame_sync) begin
            nxt_chan = '0;
            nxt_part = 1'b0;
            boundary = 1'b1;
        end else if (slot_strobe && run_q) begin
            boundary = 1'b1;
            if (chan_q == frame_len_m1 || chan_q == CH_W'(MAX_CH - 1)) begin
                nxt_chan = '0;
                nxt_part = 1'b0;
            end else begin
                nxt_chan = inc;
                if (inc[PB-1:0] == '0) begin
                    nxt_part = ~part_q;
                end
            end
        end
    end

    // Count state: running flag, slot number, partition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            chan_q <= '0;
            part_q <= 1'b0;
        end else begin
            if (frame_sync) begin
                run_q <= 1'b1;
            end
            if (boundary) begin
                chan_q <= nxt_chan;
                part_q <= nxt_part;
            end
        end
    end

endmodule

// File: rtl/tdm_chan_lookup.sv
// Bitmap lookup: picks the transmit and receive bits for a slot. In
// narrow range the bit comes from the active partition's 16-bit half;
// in wide range straight from the slot number. Assumes MAX_CH > 2*PART_CH.
module tdm_chan_lookup #(
    parameter int MAX_CH  = 128,
    parameter int PART_CH = 16,
    localparam int CH_W   = $clog2(MAX_CH),
    localparam int PB     = $clog2(PART_CH)
) (
    input  logic              wide_range,
    input  logic [CH_W-1:0]   chan,
    input  logic              part,
    input  logic [MAX_CH-1:0] tx_map,
    input  logic [MAX_CH-1:0] rx_map,
    output logic              tx_bit,
    output logic              rx_bit
);

    logic [CH_W-1:0] narrow_idx;
    logic [CH_W-1:0] idx;

    // Index selection per range setting
    always_comb begin
        narrow_idx = {{(CH_W-PB-1){1'b0}}, part, chan[PB-1:0]};
        idx        = wide_range ? chan : narrow_idx;
        tx_bit     = tx_map[idx];
        rx_bit     = rx_map[idx];
    end

endmodule

// File: rtl/tdm_mode_decode.sv
// Mode decode: turns the selection mode and the slot's two map bits
// into enable and unmask flags. Purely combinational.
module tdm_mode_decode
    import tdm_sel_pkg::*;
(
    input  logic [1:0]  sel_mode,
    input  logic        tx_bit,
    input  logic        rx_bit,
    output slot_flags_t flags
);

    // Per-mode enable and mask rule
    always_comb begin
        unique case (sel_mode_e'(sel_mode))
            SEL_ALL:     flags = '{en: 1'b1,   unmask: 1'b1};
            SEL_TX_EN:   flags = '{en: tx_bit, unmask: tx_bit};
            SEL_TX_MASK: flags = '{en: 1'b1,   unmask: tx_bit};
            SEL_SYM:     flags = '{en: rx_bit, unmask: rx_bit & tx_bit};
            default:     flags = '{en: 1'b0,   unmask: 1'b0};
        endcase
    end

endmodule

// File: rtl/tdm_tx_chan_sel.sv
// Top: TDM transmit channel selector. Counts slots from frame sync and
// registers enable, unmask and pin output-enable at each slot boundary,
// so all outputs change only with the first bit of a word. Config inputs
// are sampled at boundaries only.
module tdm_tx_chan_sel
    import tdm_sel_pkg::*;
#(
    parameter int MAX_CH  = 128,
    parameter int PART_CH = 16,
    localparam int CH_W   = $clog2(MAX_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              slot_strobe,
    input  logic [1:0]        sel_mode,
    input  logic              wide_range,
    input  logic [CH_W-1:0]   frame_len_m1,
    input  logic [MAX_CH-1:0] tx_map,
    input  logic [MAX_CH-1:0] rx_map,
    output logic [CH_W-1:0]   chan_idx,
    output logic              part_b,
    output logic              slot_enable,
    output logic              slot_unmask,
    output logic              pin_oe
);

    logic            run_q;
    logic [CH_W-1:0] nxt_chan;
    logic            nxt_part;
    logic            boundary;
    logic            tx_bit;
    logic            rx_bit;
    slot_flags_t     dec_flags;
    slot_flags_t     flags_q;
    logic            oe_q;

    tdm_slot_counter #(.MAX_CH(MAX_CH), .PART_CH(PART_CH)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_sync   (frame_sync),
        .slot_strobe  (slot_strobe),
        .frame_len_m1 (frame_len_m1),
        .run_q        (run_q),
        .chan_q       (chan_idx),
        .part_q       (part_b),
        .nxt_chan     (nxt_chan),
        .nxt_part     (nxt_part),
        .boundary     (boundary)
    );

    tdm_chan_lookup #(.MAX_CH(MAX_CH), .PART_CH(PART_CH)) u_lkp (
        .wide_range (wide_range),
        .chan       (nxt_chan),
        .part       (nxt_part),
        .tx_map     (tx_map),
        .rx_map     (rx_map),
        .tx_bit     (tx_bit),
        .rx_bit     (rx_bit)
    );

    tdm_mode_decode u_dec (
        .sel_mode (sel_mode),
        .tx_bit   (tx_bit),
        .rx_bit   (rx_bit),
        .flags    (dec_flags)
    );

    // Slot flags and pin enable, updated only at slot boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '{en: 1'b0, unmask: 1'b0};
            oe_q    <= 1'b0;
        end else if (boundary) begin
            flags_q <= dec_flags;
            oe_q    <= dec_flags.en & dec_flags.unmask;
        end
    end

    assign slot_enable = flags_q.en;
    assign slot_unmask = flags_q.unmask;
    assign pin_oe      = oe_q;

endmodule

// File: rtl/tdm_sel_chk.sv
// Checker for tdm_tx_chan_sel: timing and consistency properties of the
// slot outputs. Bound to the top below; widths match its defaults.
module tdm_sel_chk #(
    parameter int CH_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_sync,
    input logic            slot_strobe,
    input logic            wide_range,
    input logic [CH_W-1:0] frame_len_m1,
    input logic [CH_W-1:0] chan_idx,
    input logic            part_b,
    input logic            slot_enable,
    input logic            slot_unmask,
    input logic            pin_oe,
    input logic            running
);

    // R10
    oe_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> (slot_enable && slot_unmask));

    // R10
    both_gives_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_enable && slot_unmask) |-> pin_oe);

    // R2
    sync_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (chan_idx == '0 && !part_b));

    // R3
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_strobe && !frame_sync && running && chan_idx != frame_len_m1)
        |=> chan_idx == $past(chan_idx) + 1'b1);

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_strobe && !frame_sync && running && chan_idx == frame_len_m1)
        |=> (chan_idx == '0 && !part_b));

    // R11
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_strobe && !frame_sync) |=>
        ($stable(chan_idx) && $stable(pin_oe) && $stable(slot_enable)));

    // R8
    partition_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wide_range) |-> (part_b == chan_idx[4]));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!slot_enable && !pin_oe && chan_idx == '0));

endmodule

bind tdm_tx_chan_sel tdm_sel_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_sync   (frame_sync),
    .slot_strobe  (slot_strobe),
    .wide_range   (wide_range),
    .frame_len_m1 (frame_len_m1),
    .chan_idx     (chan_idx),
    .part_b       (part_b),
    .slot_enable  (slot_enable),
    .slot_unmask  (slot_unmask),
    .pin_oe       (pin_oe),
    .running      (run_q)
);

// File: tb/sim_tdm_tx_chan_sel.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks on the corner cases named in the requirements.
module sim_tdm_tx_chan_sel;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_sync = 1'b0;
    logic         slot_strobe = 1'b0;
    logic [1:0]   sel_mode = 2'b00;
    logic         wide_range = 1'b1;
    logic [6:0]   frame_len_m1 = 7'd0;
    logic [127:0] tx_map = '0;
    logic [127:0] rx_map = '0;
    logic [6:0]   chan_idx;
    logic         part_b;
    logic         slot_enable;
    logic         slot_unmask;
    logic         pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    bit r_run = 1'b0;
    int r_ch = 0;
    bit r_en = 1'b0;
    bit r_um = 1'b0;
    logic [1:0] r_mode = 2'b00;

    always #5 clk = ~clk;

    tdm_tx_chan_sel u0 (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .slot_strobe(slot_strobe), .sel_mode(sel_mode),
        .wide_range(wide_range), .frame_len_m1(frame_len_m1),
        .tx_map(tx_map), .rx_map(rx_map), .chan_idx(chan_idx),
        .part_b(part_b), .slot_enable(slot_enable),
        .slot_unmask(slot_unmask), .pin_oe(pin_oe)
    );

    function automatic logic [1:0] ref_flags(int ch, logic [1:0] m, logic w,
                                             logic [127:0] tx, logic [127:0] rx);
        int idx;
        bit t;
        bit r;
        idx = w ? ch : ((ch / 16) % 2) * 16 + (ch % 16);
        t = tx[idx];
        r = rx[idx];
        case (m)
            2'b00: return 2'b11;
            2'b01: return {t, t};
            2'b10: return {1'b1, t};
            default: return {r, r & t};
        endcase
    endfunction

    function automatic string mode_tag(logic [1:0] m);
        case (m)
            2'b00: return "R4";
            2'b01: return "R5";
            2'b10: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model update
    always @(posedge clk) begin
        logic [1:0] f;
        int nc;
        if (!rst_n) begin
            r_run <= 1'b0; r_ch <= 0; r_en <= 1'b0; r_um <= 1'b0;
        end else if (frame_sync) begin
            f = ref_flags(0, sel_mode, wide_range, tx_map, rx_map);
            r_run <= 1'b1; r_ch <= 0; r_en <= f[1]; r_um <= f[0];
            r_mode <= sel_mode;
        end else if (slot_strobe && r_run) begin
            nc = (r_ch == int'(frame_len_m1)) ? 0 : r_ch + 1;
            f = ref_flags(nc, sel_mode, wide_range, tx_map, rx_map);
            r_ch <= nc; r_en <= f[1]; r_um <= f[0];
            r_mode <= sel_mode;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(chan_idx) == r_ch, "R3 chan", chan_idx, r_ch);
            chk(part_b == bit'((r_ch / 16) % 2), "R8 part", part_b, (r_ch / 16) % 2);
            chk(slot_enable == r_en, r_run ? mode_tag(r_mode) : "R12",
                slot_enable, r_en);
            chk(slot_unmask == r_um, r_run ? mode_tag(r_mode) : "R12",
                slot_unmask, r_um);
            chk(pin_oe == (r_en & r_um), "R10 oe", pin_oe, r_en & r_um);
        end
    end

    task automatic slot(input bit sync);
        @(negedge clk);
        frame_sync = sync;
        slot_strobe = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
        slot_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200_000 * 10);
        checks++;
        errors++;
        $display("FAIL R3 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, during and just after reset
        chk(chan_idx == 0 && !part_b, "R1 count", chan_idx, 0);
        chk(!slot_enable && !slot_unmask && !pin_oe, "R1 flags",
            {slot_enable, slot_unmask, pin_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(chan_idx == 0 && !pin_oe && !slot_enable, "R1 release", chan_idx, 0);

        // R12: strobes before any frame sync are ignored
        sel_mode = 2'b01; wide_range = 1'b1; frame_len_m1 = 7'd39;
        tx_map = '0; tx_map[0] = 1'b1; tx_map[15] = 1'b1; tx_map[39] = 1'b1;
        slot(1'b0);
        slot(1'b0);
        chk(chan_idx == 0 && !slot_enable && !pin_oe, "R12 idle", chan_idx, 0);

        // R2 and R5: 40-word frame, slots 0, 15, 39 selected
        slot(1'b1);
        chk(chan_idx == 0 && pin_oe, "R2 start", {chan_idx, pin_oe}, 1);
        for (int s = 1; s < 40; s++) begin
            slot(1'b0);
            if (s == 15 || s == 39)
                chk(pin_oe && slot_enable, "R5 selected", pin_oe, 1);
            if (s == 20)
                chk(!pin_oe && !slot_enable, "R5 unselected", pin_oe, 0);
        end
        slot(1'b0);
        chk(chan_idx == 0, "R3 wrap", chan_idx, 0);

        // R11: bitmap change in mid-slot waits for the next boundary
        tx_map = '0;
        @(negedge clk);
        chk(pin_oe == 1'b1, "R11 hold", pin_oe, 1);
        slot(1'b1);
        chk(pin_oe == 1'b0, "R11 applied", pin_oe, 0);

        // R6 and R8: narrow range, 64-word frame, upper map bits set
        sel_mode = 2'b10; wide_range = 1'b0; frame_len_m1 = 7'd63;
        tx_map = '0;
        tx_map[127:96] = 32'hFFFF_FFFF;
        tx_map[31:0] = 32'hA5A5_0F0F;
        slot(1'b1);
        for (int s = 1; s < 64; s++) begin
            slot(1'b0);
            if (s == 4)
                chk(slot_enable && !pin_oe, "R6 masked", {slot_enable, pin_oe}, 2);
            if (s == 40)
                chk(pin_oe && !part_b, "R8 block2 partA", {pin_oe, part_b}, 2);
            if (s == 48)
                chk(pin_oe && part_b, "R8 block3 partB", {pin_oe, part_b}, 3);
        end

        // R7: symmetric mode
        sel_mode = 2'b11; frame_len_m1 = 7'd31;
        rx_map = '0; rx_map[31:0] = 32'h00FF_FF00;
        tx_map = '0; tx_map[31:0] = 32'h0F0F_F0F0;
        slot(1'b1);
        chk(!slot_enable && !pin_oe, "R7 no rx", slot_enable, 0);
        for (int s = 1; s < 32; s++) begin
            slot(1'b0);
            if (s == 8)
                chk(slot_enable && !pin_oe, "R7 rx only", {slot_enable, pin_oe}, 2);
            if (s == 12)
                chk(slot_enable && pin_oe, "R7 rx and tx", {slot_enable, pin_oe}, 3);
        end

        // R4: all-channel mode ignores empty bitmaps
        sel_mode = 2'b00; wide_range = 1'b1; frame_len_m1 = 7'd127;
        tx_map = '0; rx_map = '0;
        slot(1'b1);
        for (int s = 1; s < 6; s++) slot(1'b0);
        chk(slot_enable && slot_unmask && pin_oe, "R4 all", pin_oe, 1);

        // R9: wide range, slot 100 selected
        sel_mode = 2'b01; tx_map = '0; tx_map[100] = 1'b1;
        slot(1'b1);
        for (int s = 1; s <= 100; s++) begin
            slot(1'b0);
            if (s == 100)
                chk(pin_oe && chan_idx == 100, "R9 wide idx", chan_idx, 100);
            if (s == 36)
                chk(!pin_oe, "R9 no alias", pin_oe, 0);
        end

        // R2: resync in the middle of a frame
        slot(1'b1);
        chk(chan_idx == 0 && !part_b, "R2 resync", chan_idx, 0);

        @(negedge clk);
        finish_run();
    end

endmodule